// File: doc/BRIEF.md
# Carry-Chain Wide Match Decoder

This block decides whether a wide address bus equals a match pattern. It does not use a balanced tree of gates. It splits the bus into four-bit slices. Each slice has a small function that reports whether its bits equal the corresponding pattern bits, and that result drives the select of a 2:1 carry multiplexer. The multiplexers form one serial chain. A fixed seed enters at the first stage, and a fixed constant sits on every direct input. Together these two constants turn the chain into a wide AND or a wide OR.

A static mode input picks one of two reductions. In equality mode the chain reports that every slice matched. In difference mode it reports that at least one slice mismatched. A static invert input complements the chain output, which gives the NAND and NOR forms. The combinational flag is also available as a registered copy. A parameter selects whether that copy is a real flop or a plain wire.

When the bus width is not a multiple of four, the unused positions in the last slice are treated as matching. Padding therefore never changes the result in either mode. The default configuration is a 64-bit decoder with 16 stages.

Top module: `wide_gate_decoder`

## Requirements
- R1: With mode_i = 0 (equality) and invert_i = 0, match_o is 1 exactly when addr_i equals pattern_i in all WIDTH bits.
- R2: With mode_i = 1 (difference) and invert_i = 0, match_o is 1 exactly when addr_i differs from pattern_i in at least one bit.
- R3: With invert_i = 1, match_o is the complement of the value R1 or R2 gives for the same mode and inputs.
- R4: Flipping any single bit of addr_i away from pattern_i, in any stage, drives match_o to 0 in equality mode and to 1 in difference mode.
- R5: With REG_OUT = 1, match_q_o is 0 while rst_n is low, and after each rising clk edge it holds the match_o value present just before that edge.
- R6: When WIDTH is not a multiple of 4, the padded positions of the last stage count as matching. A full match then gives 1 in equality mode and 0 in difference mode.
- R7: Along the chain, the stage outputs are monotonic. In equality mode, once a stage output is 0, every later stage output is 0. In difference mode, once a stage output is 1, every later stage output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Active-low asynchronous reset of the registered copy |
| mode_i | input | 1 | 0 selects the equality (wide AND) chain, 1 selects the difference (wide OR) chain |
| invert_i | input | 1 | 1 complements the chain result |
| addr_i | input | WIDTH | Address bus under test |
| pattern_i | input | WIDTH | Pattern to compare against |
| match_o | output | 1 | Combinational match flag |
| match_q_o | output | 1 | Registered copy of match_o |

## Verification
Several stimulus patterns are applied, and each one exposes a different class of fault.
- An exact match separates a correct seed constant from a wrong one.
- A single-bit sweep over every position of both modes exposes a broken stage, a mis-wired carry link, or a bad bit inside a slice.
- Random addresses, mostly far from the pattern, show that the difference chain really ORs across stages instead of echoing the last one.
- A 10-bit instance, with its half-filled last slice, shows that the padding is neutral in both modes.
- Held and changed inputs around clock edges tell the registered copy apart from the combinational flag.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    localparam int LANE_BITS = 4;

    typedef enum logic {
        RED_AND = 1'b0,
        RED_OR  = 1'b1
    } red_mode_e;

    // Carry seed entering the first stage for each reduction.
    function automatic logic seed_of(red_mode_e m);
        return (m == RED_OR) ? 1'b0 : 1'b1;
    endfunction

    // Constant on every direct input for each reduction.
    function automatic logic direct_of(red_mode_e m);
        return (m == RED_OR) ? 1'b1 : 1'b0;
    endfunction

    function automatic int stages_for(int width);
        return (width + LANE_BITS - 1) / LANE_BITS;
    endfunction

endpackage

// File: rtl/wgd_lane_func.sv
module wgd_lane_func
    import wgd_pkg::*;
(
    input  logic [LANE_BITS-1:0] addr_nib,
    input  logic [LANE_BITS-1:0] pat_nib,
    input  logic [LANE_BITS-1:0] live_nib,
    output logic                 sel
);
    logic [LANE_BITS-1:0] bit_eq;

    always_comb begin
        // Dead (padding) positions always count as equal.
        bit_eq = ~(addr_nib ^ pat_nib) | ~live_nib;
        sel    = &bit_eq;
    end

    always_comb begin
        assert (!(sel && ((addr_nib & live_nib) != (pat_nib & live_nib))))
            else $error("AST_LANE_EQ");  // R6
    end
endmodule

// File: rtl/wgd_carry_mux.sv
module wgd_carry_mux (
    input  logic sel,
    input  logic ci,
    input  logic di,
    output logic co
);
    always_comb begin
        co = sel ? ci : di;
    end
endmodule

// File: rtl/wgd_chain.sv
module wgd_chain
    import wgd_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int STAGES = stages_for(WIDTH),
    localparam int PAD_W  = STAGES * LANE_BITS
) (
    input  logic              mode,
    input  logic [WIDTH-1:0]  addr,
    input  logic [WIDTH-1:0]  pattern,
    output logic [STAGES-1:0] carry,
    output logic              result
);
    logic [PAD_W-1:0]  a_ext;
    logic [PAD_W-1:0]  p_ext;
    logic [PAD_W-1:0]  live;
    logic [STAGES-1:0] sel;
    logic              seed;
    logic              direct;

    always_comb begin
        seed   = seed_of(red_mode_e'(mode));
        direct = direct_of(red_mode_e'(mode));
    end

    for (genvar b = 0; b < PAD_W; b++) begin : g_bit
        if (b < WIDTH) begin : g_live
            assign a_ext[b] = addr[b];
            assign p_ext[b] = pattern[b];
            assign live[b]  = 1'b1;
        end else begin : g_pad
            assign a_ext[b] = 1'b0;
            assign p_ext[b] = 1'b0;
            assign live[b]  = 1'b0;
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic ci;
        if (s == 0) begin : g_first
            assign ci = seed;
        end else begin : g_link
            assign ci = carry[s-1];
        end

        wgd_lane_func u_func (
            .addr_nib (a_ext[s*LANE_BITS +: LANE_BITS]),
            .pat_nib  (p_ext[s*LANE_BITS +: LANE_BITS]),
            .live_nib (live[s*LANE_BITS +: LANE_BITS]),
            .sel      (sel[s])
        );

        wgd_carry_mux u_mux (
            .sel (sel[s]),
            .ci  (ci),
            .di  (direct),
            .co  (carry[s])
        );
    end

    assign result = carry[STAGES-1];
endmodule

// File: rtl/wide_gate_decoder.sv
module wide_gate_decoder
    import wgd_pkg::*;
#(
    parameter int WIDTH   = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int STAGES = stages_for(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             invert_i,
    input  logic [WIDTH-1:0] addr_i,
    input  logic [WIDTH-1:0] pattern_i,
    output logic             match_o,
    output logic             match_q_o
);
    typedef struct packed {
        logic match;
    } flag_t;

    logic [STAGES-1:0] carry;
    logic              chain_out;
    flag_t             flag_d;
    flag_t             flag_q;

    wgd_chain #(.WIDTH(WIDTH)) u_chain (
        .mode    (mode_i),
        .addr    (addr_i),
        .pattern (pattern_i),
        .carry   (carry),
        .result  (chain_out)
    );

    always_comb begin
        flag_d       = flag_q;
        flag_d.match = chain_out ^ invert_i;
    end

    assign match_o = flag_d.match;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= '0;
            end else begin
                flag_q <= flag_d;
            end
        end
        assign match_q_o = flag_q.match;

        AST_Q_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> match_q_o == $past(match_o)) else $error("AST_Q_FOLLOWS");  // R5
    end else begin : g_wire
        assign flag_q    = '0;
        assign match_q_o = match_o;
    end

    AST_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !invert_i) |-> (match_o == (addr_i == pattern_i)))
        else $error("AST_AND_FULL");  // R1
    AST_OR_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !invert_i) |-> (match_o == (addr_i != pattern_i)))
        else $error("AST_OR_ANY");  // R2
    AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        invert_i |-> (match_o != chain_out)) else $error("AST_INVERT");  // R3

    for (genvar s = 1; s < STAGES; s++) begin : g_mono
        AST_CHAIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i ? carry[s-1] : !carry[s-1]) |-> (carry[s] == carry[s-1]))
            else $error("AST_CHAIN_MONO");  // R7
    end
endmodule

// File: tb/wide_gate_decoder_bench.sv
module wide_gate_decoder_bench;
    localparam int W  = 64;
    localparam int WO = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          invert_i = 1'b0;
    logic [W-1:0]  addr_i = '0;
    logic [W-1:0]  pattern_i = '0;
    logic          match_o, match_q_o;
    logic [WO-1:0] o_addr = '0;
    logic [WO-1:0] o_pat = '0;
    logic          o_match, o_match_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wide_gate_decoder #(.WIDTH(W)) u_wide_gate_decoder (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .invert_i(invert_i),
        .addr_i(addr_i), .pattern_i(pattern_i),
        .match_o(match_o), .match_q_o(match_q_o)
    );

    wide_gate_decoder #(.WIDTH(WO)) u_odd (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .invert_i(invert_i),
        .addr_i(o_addr), .pattern_i(o_pat),
        .match_o(o_match), .match_q_o(o_match_q)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic model(input logic m, input logic inv,
                                   input logic [W-1:0] a, input logic [W-1:0] p);
        logic r;
        r = m ? (a != p) : (a == p);
        return r ^ inv;
    endfunction

    task automatic apply(input logic m, input logic inv,
                         input logic [W-1:0] a, input logic [W-1:0] p);
        @(negedge clk);
        mode_i = m; invert_i = inv; addr_i = a; pattern_i = p;
        #1;
    endtask

    task automatic t_reset;
        #1;
        chk(match_q_o, 1'b0, "R5 reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_full_match;
        logic [W-1:0] p;
        p = 64'hA5C3_0F1E_9876_DEAD;
        apply(1'b0, 1'b0, p, p); chk(match_o, 1'b1, "R1 equal");
        apply(1'b1, 1'b0, p, p); chk(match_o, 1'b0, "R2 equal");
        apply(1'b0, 1'b0, '1, '1); chk(match_o, 1'b1, "R1 ones");
        apply(1'b1, 1'b0, '0, '0); chk(match_o, 1'b0, "R2 zeros");
    endtask

    task automatic t_single_bit;
        logic [W-1:0] p;
        p = 64'h1357_9BDF_2468_ACE0;
        for (int b = 0; b < W; b++) begin
            apply(1'b0, 1'b0, p ^ (64'd1 << b), p);
            chk(match_o, 1'b0, "R4 and-mode flip");
            apply(1'b1, 1'b0, p ^ (64'd1 << b), p);
            chk(match_o, 1'b1, "R4 or-mode flip");
        end
    endtask

    task automatic t_random;
        logic [W-1:0] a, p;
        for (int i = 0; i < 40; i++) begin
            p = {$urandom, $urandom};
            a = (i % 3 == 0) ? p : {$urandom, $urandom};
            apply(1'b0, 1'b0, a, p); chk(match_o, model(1'b0, 1'b0, a, p), "R1 random");
            apply(1'b1, 1'b0, a, p); chk(match_o, model(1'b1, 1'b0, a, p), "R2 random");
        end
    endtask

    task automatic t_invert;
        logic [W-1:0] p;
        p = 64'hFEDC_BA98_7654_3210;
        apply(1'b0, 1'b1, p, p);         chk(match_o, 1'b0, "R3 nand equal");
        apply(1'b0, 1'b1, p ^ 64'h8, p); chk(match_o, 1'b1, "R3 nand differ");
        apply(1'b1, 1'b1, p, p);         chk(match_o, 1'b1, "R3 nor equal");
        apply(1'b1, 1'b1, p ^ 64'h8000_0000_0000_0000, p);
        chk(match_o, 1'b0, "R3 nor differ");
    endtask

    task automatic t_register;
        logic [W-1:0] p;
        p = 64'h0123_4567_89AB_CDEF;
        apply(1'b0, 1'b0, p, p);
        @(negedge clk);
        chk(match_q_o, 1'b1, "R5 captured match");
        addr_i = p ^ 64'h10; #1;
        chk(match_o, 1'b0, "R5 comb moved");
        chk(match_q_o, 1'b1, "R5 held until edge");
        @(negedge clk);
        chk(match_q_o, 1'b0, "R5 captured mismatch");
    endtask

    task automatic t_odd_width;
        @(negedge clk);
        invert_i = 1'b0;
        o_pat = 10'h2B7;
        o_addr = 10'h2B7;
        mode_i = 1'b0; #1; chk(o_match, 1'b1, "R6 padded and-mode match");
        mode_i = 1'b1; #1; chk(o_match, 1'b0, "R6 padded or-mode match");
        o_addr = 10'h2B7 ^ 10'h200;
        mode_i = 1'b0; #1; chk(o_match, 1'b0, "R6 top live bit and-mode");
        mode_i = 1'b1; #1; chk(o_match, 1'b1, "R6 top live bit or-mode");
    endtask

    // R7 is watched by the chain assertions while every test runs.
    initial begin
        t_reset();
        t_full_match();
        t_single_bit();
        t_random();
        t_invert();
        t_register();
        t_odd_width();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule